// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit takes two 32-bit operands and performs several independent additions or subtractions on them in one step. The operand word is split into four 8-bit lanes or two 16-bit lanes. Two further operations cross the halfwords: the high half of one operand is paired with the low half of the other, so that one half is added and the other subtracted. No carry or borrow passes from one lane into the next, and every lane result wraps modulo its own width.

Next to the 32-bit result, the unit produces four greater-or-equal flags, one per byte position. A later select step can use them to pick bytes from two sources. A signed/unsigned input chooses how the flags are formed. Result and flags are registered, so they appear one clock after the inputs. An operation code that names no operation gives a zero result and leaves the flags as they were.

Top module: `simd_addsub`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o` and `ge_o` become zero.
- R2: Result and flags reflect the inputs sampled at the previous rising edge (one cycle of latency).
- R3: Code 3'd0 adds the four byte lanes independently; each lane wraps modulo 256 and no carry crosses a byte boundary.
- R4: Code 3'd1 subtracts each byte lane of `opb_i` from the same lane of `opa_i`, modulo 256, with no borrow crossing lanes.
- R5: Code 3'd2 adds and code 3'd3 subtracts the two 16-bit halves independently, modulo 65536.
- R6: Code 3'd4 gives high half = opa[31:16] + opb[15:0] and low half = opa[15:0] - opb[31:16].
- R7: Code 3'd5 gives high half = opa[31:16] - opb[15:0] and low half = opa[15:0] + opb[31:16].
- R8: With `signed_i` low, a lane flag is set on carry-out for an add and when no borrow occurs for a subtract.
- R9: With `signed_i` high, a lane flag is set when the exact (unwrapped) signed result of that lane is zero or positive.
- R10: For codes 0 and 1, `ge_o[i]` belongs to byte lane i (bits 8i+7:8i). For codes 2 to 5, the low-half flag drives `ge_o[1:0]` and the high-half flag drives `ge_o[3:2]`.
- R11: Codes 3'd6 and 3'd7 produce a zero result and leave `ge_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code |
| signed_i | input | 1 | 1 = signed flag rule, 0 = unsigned |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| result_o | output | 32 | Registered packed result |
| ge_o | output | 4 | Registered greater-or-equal flags |

## Verification
Each lane is a separate adder, so a fault in lane isolation or in operand steering shows up one cycle later as a wrong byte or halfword of `result_o`. Only the affected lane is wrong; the others stay correct. A wrong flag rule or a wrong flag copy pattern shows in `ge_o` in that same cycle. A mistake in holding the flags on an unused code only appears once the next cycle's `ge_o` is compared with the previous one. For that reason the bench keeps its own running copy of the expected flags and checks every cycle.

// File: rtl/simd_as_pkg.sv
package simd_as_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int N_LANE = DATA_W / BYTE_W;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [2:0] {
        OP_ADD8  = 3'd0,
        OP_SUB8  = 3'd1,
        OP_ADD16 = 3'd2,
        OP_SUB16 = 3'd3,
        OP_ASX   = 3'd4,
        OP_SAX   = 3'd5
    } simd_op_e;

    typedef struct packed {
        logic       valid;
        logic       byte_mode;
        logic       swap;
        logic       byte_sub;
        logic [1:0] half_sub;
    } simd_ctl_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [N_LANE-1:0] ge;
    } simd_out_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
    import simd_as_pkg::*;
(
    input  logic [2:0] op_i,
    output simd_ctl_t  ctl_o
);
    always_comb begin
        ctl_o           = '0;
        ctl_o.valid     = op_known(op_i);
        ctl_o.byte_mode = (op_i == OP_ADD8) || (op_i == OP_SUB8);
        ctl_o.byte_sub  = (op_i == OP_SUB8);
        ctl_o.swap      = (op_i == OP_ASX) || (op_i == OP_SAX);
        case (op_i)
            OP_SUB16: ctl_o.half_sub = 2'b11;
            OP_ASX:   ctl_o.half_sub = 2'b01;
            OP_SAX:   ctl_o.half_sub = 2'b10;
            default:  ctl_o.half_sub = 2'b00;
        endcase
    end
endmodule

// File: rtl/simd_lane_arith.sv
module simd_lane_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         sgn_i,
    output logic [W-1:0] res_o,
    output logic         ge_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] ax, bx, sum;

    always_comb begin
        ax    = {sgn_i & a_i[W-1], a_i};
        bx    = {sgn_i & b_i[W-1], b_i};
        sum   = sub_i ? (ax - bx) : (ax + bx);
        res_o = sum[W-1:0];
        ge_o  = (!sub_i && !sgn_i) ? sum[W] : ~sum[W];
    end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_as_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op_i,
    input  logic        signed_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    output logic [31:0] result_o,
    output logic [3:0]  ge_o
);
    localparam int HALF_FLAGS = N_LANE / 2;

    simd_ctl_t ctl;
    simd_out_t nxt, cur;

    logic [DATA_W-1:0] byte_res, half_res;
    logic [N_LANE-1:0] byte_ge;
    logic [1:0]        half_ge;
    logic [N_LANE-1:0] half_ge_wide;

    simd_op_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    for (genvar i = 0; i < N_LANE; i++) begin : g_byte
        simd_lane_arith #(.W(BYTE_W)) u_lane (
            .a_i   (opa_i[i*BYTE_W +: BYTE_W]),
            .b_i   (opb_i[i*BYTE_W +: BYTE_W]),
            .sub_i (ctl.byte_sub),
            .sgn_i (signed_i),
            .res_o (byte_res[i*BYTE_W +: BYTE_W]),
            .ge_o  (byte_ge[i])
        );
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] b_sel;
        assign b_sel = ctl.swap ? opb_i[(1-h)*HALF_W +: HALF_W]
                                : opb_i[h*HALF_W +: HALF_W];
        simd_lane_arith #(.W(HALF_W)) u_lane (
            .a_i   (opa_i[h*HALF_W +: HALF_W]),
            .b_i   (b_sel),
            .sub_i (ctl.half_sub[h]),
            .sgn_i (signed_i),
            .res_o (half_res[h*HALF_W +: HALF_W]),
            .ge_o  (half_ge[h])
        );
        assign half_ge_wide[h*HALF_FLAGS +: HALF_FLAGS] = {HALF_FLAGS{half_ge[h]}};
    end

    always_comb begin
        nxt = cur;
        if (!ctl.valid) begin
            nxt.res = '0;
        end else if (ctl.byte_mode) begin
            nxt.res = byte_res;
            nxt.ge  = byte_ge;
        end else begin
            nxt.res = half_res;
            nxt.ge  = half_ge_wide;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign result_o = cur.res;
    assign ge_o     = cur.ge;
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_i,
    input logic        signed_i,
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic [31:0] result_o,
    input logic [3:0]  ge_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result_o == 32'd0 && ge_o == 4'd0));

    assert_byte_add_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0) |=> (result_o[15:8] == $past(opa_i[15:8] + opb_i[15:8])));

    assert_asx_high_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4) |=> (result_o[31:16] == $past(opa_i[31:16] + opb_i[15:0])));

    assert_sax_low_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5) |=> (result_o[15:0] == $past(opa_i[15:0] + opb_i[31:16])));

    assert_half_flag_pairs_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 3'd2 && op_i <= 3'd5) |=> (ge_o[3] == ge_o[2] && ge_o[1] == ge_o[0]));

    assert_unsigned_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 && !signed_i) |=>
            (ge_o[0] == ($past({1'b0, opa_i[7:0]}) + $past({1'b0, opb_i[7:0]}) > 9'd255)));

    assert_unused_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (op_i > 3'd5) |=> (result_o == 32'd0 && $stable(ge_o)));
endmodule

bind simd_addsub simd_addsub_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .signed_i (signed_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .result_o (result_o),
    .ge_o     (ge_o)
);

// File: tb/simd_addsub_test.sv
module simd_addsub_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic        signed_i;
    logic [31:0] opa_i, opb_i;
    logic [31:0] result_o;
    logic [3:0]  ge_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_ge_state;

    simd_addsub uut (
        .clk(clk), .rst(rst), .op_i(op_i), .signed_i(signed_i),
        .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .ge_o(ge_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One lane: returns {ge, result} for a lane of width w.
    function automatic logic [16:0] lane_model(input int w, input logic [15:0] a,
                                               input logic [15:0] b, input logic sub,
                                               input logic sgn);
        longint m = (longint'(1) << w);
        longint av = longint'(a) & (m - 1);
        longint bv = longint'(b) & (m - 1);
        longint s;
        logic g;
        if (sgn && av >= m/2) av = av - m;
        if (sgn && bv >= m/2) bv = bv - m;
        s = sub ? av - bv : av + bv;
        g = (!sub && !sgn) ? (s >= m) : (s >= 0);
        return {g, 16'(s & (m - 1))};
    endfunction

    function automatic string req_of(input logic [2:0] op, input logic sgn);
        case (op)
            3'd0: return sgn ? "R3/R9/R10" : "R3/R8/R10";
            3'd1: return sgn ? "R4/R9/R10" : "R4/R8/R10";
            3'd2, 3'd3: return sgn ? "R5/R9/R10" : "R5/R8/R10";
            3'd4: return "R6/R10";
            3'd5: return "R7/R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] er, input logic [3:0] eg);
        checks++;
        if (result_o !== er || ge_o !== eg) begin
            fails++;
            $display("FAIL %s: op=%0d sgn=%0b a=%h b=%h actual res=%h ge=%b expected res=%h ge=%b",
                     tag, op_i, signed_i, opa_i, opb_i, result_o, ge_o, er, eg);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (R2).
    task automatic run_op(input logic [2:0] op, input logic sgn,
                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [3:0]  eg;
        logic [16:0] l0, l1;
        op_i = op; signed_i = sgn; opa_i = a; opb_i = b;
        er = '0; eg = exp_ge_state;
        case (op)
            3'd0, 3'd1: begin
                for (int i = 0; i < 4; i++) begin
                    l0 = lane_model(8, {8'd0, a[i*8 +: 8]}, {8'd0, b[i*8 +: 8]}, op[0], sgn);
                    er[i*8 +: 8] = l0[7:0];
                    eg[i] = l0[16];
                end
            end
            3'd2, 3'd3: begin
                l0 = lane_model(16, a[15:0], b[15:0], op[0], sgn);
                l1 = lane_model(16, a[31:16], b[31:16], op[0], sgn);
                er = {l1[15:0], l0[15:0]};
                eg = {l1[16], l1[16], l0[16], l0[16]};
            end
            3'd4, 3'd5: begin
                l1 = lane_model(16, a[31:16], b[15:0], op == 3'd5, sgn);
                l0 = lane_model(16, a[15:0], b[31:16], op == 3'd4, sgn);
                er = {l1[15:0], l0[15:0]};
                eg = {l1[16], l1[16], l0[16], l0[16]};
            end
            default: ;
        endcase
        exp_ge_state = eg;
        @(negedge clk);
        compare({"R2 ", req_of(op, sgn)}, er, eg);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        fails++;
        $display("FAIL watchdog: actual=expired expected=completed");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; op_i = 3'd0; signed_i = 1'b0; opa_i = '0; opb_i = '0;
        @(negedge clk);
        opa_i = 32'hFFFF_FFFF; opb_i = 32'h0101_0101;
        @(negedge clk);
        compare("R1", 32'd0, 4'd0);
        rst = 1'b0;
        exp_ge_state = 4'd0;

        // R3 carry isolation, R8 unsigned carry-out
        run_op(3'd0, 1'b0, 32'h00FF_00FF, 32'h0001_0001);
        // R4 borrow isolation, R8 no-borrow rule
        run_op(3'd1, 1'b0, 32'h0100_0005, 32'h0001_0006);
        // R9 signed overflow cases: -128-1 and 127+1
        run_op(3'd1, 1'b1, 32'h0000_0080, 32'h0000_0001);
        run_op(3'd0, 1'b1, 32'h7F7F_7F7F, 32'h0101_0101);
        // R5 halfword boundaries
        run_op(3'd2, 1'b0, 32'hFFFF_FFFF, 32'h0001_0000);
        run_op(3'd3, 1'b1, 32'h8000_0000, 32'h0001_0001);
        // R6 / R7 exchange
        run_op(3'd4, 1'b0, 32'h1234_0010, 32'h0020_0001);
        run_op(3'd5, 1'b1, 32'h0001_FFFF, 32'h0002_0001);
        // R11 flags hold, result zero
        run_op(3'd0, 1'b0, 32'hFF00_FF00, 32'h0100_0100);
        run_op(3'd6, 1'b0, 32'h1111_1111, 32'h2222_2222);
        run_op(3'd7, 1'b1, 32'h8080_8080, 32'h8080_8080);
        // reset mid-run clears state again (R1)
        rst = 1'b1;
        @(negedge clk);
        compare("R1", 32'd0, 4'd0);
        rst = 1'b0;
        exp_ge_state = 4'd0;

        for (int n = 0; n < 600; n++) begin
            run_op(3'($urandom % 8), 1'($urandom % 2), $urandom, $urandom);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule